// File: doc/BRIEF.md
# Test Pattern Word Injector

This block holds a small ring of link test words. It replays them into a serial link's word stream when a test mode is on. Configuration logic presents three things to the block:

- a pattern field;
- a load strobe bit;
- a mode enable bit.

Each time the strobe goes from low to high, the current pattern field is stored in the next cell of an eight-cell ring. The write position wraps after the last cell.

Each stored entry is 54 bits wide:

- bits 47:0 hold six 8-bit characters;
- bits 53:48 hold one flag per character, marking it as either a data character or a control (comma-type) character.

When the mode is enabled, the block raises a slot request towards the link scheduler. It then presents the entries starting at cell 0. It moves to the next cell each time the scheduler grants a slot. Playback always delivers complete rounds of eight entries: after the enable is cleared, the request stays up until the grant for the last cell has been taken. The word count on the link is therefore always a multiple of eight.

Top module: `tpat_injector`

## Requirements
- R1: While reset is applied and afterwards, `slot_req` is low, every cell holds zero, and both the write position and the playback position are cell 0. Reset is synchronous and active high.
- R2: The entry presented on the outputs maps onto the stored pattern field as follows. `tp_chars` carries bits 47:0, with character i at bits 8i+7:8i. `tp_kflags` carries bits 53:48, where bit i flags character i as control (1) or data (0).
- R3: Each low-to-high transition of `cfg_new_data` writes `cfg_tp_data` into the cell at the write position, and the write takes effect at the clock edge where the high level is first sampled. The position then advances by one and wraps from cell 7 to cell 0. A strobe held high writes only once.
- R4: The playback position advances only on a clock edge where `slot_req` and `slot_grant` are both high. Without a grant, the presented entry stays the same.
- R5: Every playback round starts at cell 0 and presents cells 0 through 7 in ascending order, then repeats.
- R6: When `cfg_tp_enable` is low at the edge where the grant for cell 7 is taken, `slot_req` falls after that edge. Clearing the enable at any other point does not shorten the round in progress.
- R7: While idle, a high `cfg_tp_enable` sampled at a clock edge raises `slot_req` from the next cycle on.
- R8: If a write and a granted read hit the same cell in one cycle, the outputs show the old content in that cycle. The new content appears the next time the cell is presented.
- R9: `slot_grant` has no effect while `slot_req` is low.
- R10: Changes of `cfg_tp_data` without a rising strobe do not alter any stored cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_new_data | input | 1 | Load strobe; its rising edge stores one entry |
| cfg_tp_enable | input | 1 | Test-pattern mode enable |
| cfg_tp_data | input | 54 | Pattern field: control flags in 53:48, characters in 47:0 |
| slot_grant | input | 1 | Scheduler grant for the presented entry |
| slot_req | output | 1 | Request for a test-pattern slot |
| tp_chars | output | 48 | Six characters of the presented entry |
| tp_kflags | output | 6 | Control/data flags of the presented entry |

## Verification
Two functions can fall in the same cycle: loading a cell and handing a granted read of that same cell to the scheduler. The bench provokes this on purpose. It steps playback until the read position equals the write position, then raises the strobe in the very cycle the grant is given. It expects the old entry on the outputs in that cycle and the new entry one round later. Random phases also mix strobe edges, grants and enable toggles, so loads during playback and stops in the middle of a round are covered too.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    localparam int unsigned CHAR_W    = 8;
    localparam int unsigned NUM_CHARS = 6;
    localparam int unsigned WORD_W    = CHAR_W * NUM_CHARS;
    localparam int unsigned ENTRY_W   = WORD_W + NUM_CHARS;

    // Flags in the upper bits, characters in the lower bits.
    typedef struct packed {
        logic [NUM_CHARS-1:0] kflags;
        logic [WORD_W-1:0]    chars;
    } tp_entry_t;

    typedef enum logic {
        PB_IDLE = 1'b0,
        PB_RUN  = 1'b1
    } pb_state_t;

    function automatic tp_entry_t to_entry(input logic [ENTRY_W-1:0] raw);
        return tp_entry_t'(raw);
    endfunction

endpackage

// File: rtl/tpat_edge_rise.sv
module tpat_edge_rise (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic pulse_o
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level_i;
    end

    assign pulse_o = level_i & ~level_q;

    // R3: a held strobe yields exactly one write pulse
    p_one_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/tpat_cell_store.sv
module tpat_cell_store
    import tpat_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 8,
    localparam int unsigned PTR_W    = $clog2(NUM_CELLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  tp_entry_t        wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output tp_entry_t        rd_data
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CELLS - 1);

    logic [PTR_W-1:0] wr_ptr;
    tp_entry_t        cells [NUM_CELLS];

    always_ff @(posedge clk) begin
        if (rst)        wr_ptr <= '0;
        else if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[c] <= '0;
            else if (wr_en && wr_ptr == PTR_W'(c))
                cells[c] <= wr_data;
        end
    end

    assign rd_data = cells[rd_ptr];

    // R3: write position wraps from the last cell to cell 0
    p_wr_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ptr == LAST) |=> wr_ptr == '0);

    // R10: without a write the position stays put
    p_wr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(wr_ptr));

endmodule

// File: rtl/tpat_playback.sv
module tpat_playback
    import tpat_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 8,
    localparam int unsigned PTR_W    = $clog2(NUM_CELLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             grant_i,
    output logic             req_o,
    output logic [PTR_W-1:0] rd_ptr_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CELLS - 1);

    pb_state_t state;
    logic      take;
    logic      at_last;

    assign req_o   = (state == PB_RUN);
    assign take    = req_o & grant_i;
    assign at_last = (rd_ptr_o == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PB_IDLE;
            rd_ptr_o <= '0;
        end else begin
            case (state)
                PB_IDLE: if (enable_i) state <= PB_RUN;
                PB_RUN: begin
                    if (take) begin
                        rd_ptr_o <= at_last ? '0 : rd_ptr_o + 1'b1;
                        if (at_last && !enable_i) state <= PB_IDLE;
                    end
                end
                default: state <= PB_IDLE;
            endcase
        end
    end

    // R4 / R9: position moves only on a taken grant
    p_hold_rd_r4: assert property (@(posedge clk) disable iff (rst)
        !(req_o && grant_i) |=> $stable(rd_ptr_o));

    // R5: every round begins at cell 0
    p_start_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> rd_ptr_o == '0);

    // R6: request only drops right after the grant of the last cell
    p_stop_last_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(req_o) |-> ($past(grant_i) && $past(rd_ptr_o) == LAST && !$past(enable_i)));

    // R6: enabled playback keeps requesting
    p_keep_run_r6: assert property (@(posedge clk) disable iff (rst)
        (req_o && enable_i) |=> req_o);

    // R7: idle plus enable raises the request next cycle
    p_start_r7: assert property (@(posedge clk) disable iff (rst)
        (!req_o && enable_i) |=> req_o);

endmodule

// File: rtl/tpat_injector.sv
module tpat_injector
    import tpat_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 8,
    localparam int unsigned PTR_W    = $clog2(NUM_CELLS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_new_data,
    input  logic               cfg_tp_enable,
    input  logic [ENTRY_W-1:0] cfg_tp_data,
    input  logic               slot_grant,
    output logic               slot_req,
    output logic [WORD_W-1:0]  tp_chars,
    output logic [NUM_CHARS-1:0] tp_kflags
);
    logic             wr_pulse;
    logic [PTR_W-1:0] rd_ptr;
    tp_entry_t        rd_entry;

    tpat_edge_rise u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (cfg_new_data),
        .pulse_o (wr_pulse)
    );

    tpat_cell_store #(.NUM_CELLS(NUM_CELLS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_pulse),
        .wr_data (to_entry(cfg_tp_data)),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_entry)
    );

    tpat_playback #(.NUM_CELLS(NUM_CELLS)) u_play (
        .clk      (clk),
        .rst      (rst),
        .enable_i (cfg_tp_enable),
        .grant_i  (slot_grant),
        .req_o    (slot_req),
        .rd_ptr_o (rd_ptr)
    );

    assign tp_chars  = rd_entry.chars;
    assign tp_kflags = rd_entry.kflags;

    // R1: no request while in reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !slot_req);

endmodule

// File: tb/tpat_injector_tb_top.sv
module tpat_injector_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [53:0] KNOWN = {6'b101001, 48'h66_55_44_33_22_11};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_new_data = 1'b0;
    logic        cfg_tp_enable = 1'b0;
    logic [53:0] cfg_tp_data = '0;
    logic        slot_grant = 1'b0;
    logic        slot_req;
    logic [47:0] tp_chars;
    logic [5:0]  tp_kflags;

    int checks = 0;
    int errors = 0;

    logic [53:0] m_cells [8];
    int          m_wr = 0;
    int          m_rd = 0;
    bit          m_act = 0;
    bit          m_sq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpat_injector dut_i (
        .clk(clk), .rst(rst), .cfg_new_data(cfg_new_data),
        .cfg_tp_enable(cfg_tp_enable), .cfg_tp_data(cfg_tp_data),
        .slot_grant(slot_grant), .slot_req(slot_req),
        .tp_chars(tp_chars), .tp_kflags(tp_kflags)
    );

    function automatic logic [53:0] rnd_entry();
        return {$urandom, $urandom};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [53:0] act, input logic [53:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock cycle: drive, compare with the model, advance the model.
    task automatic step(input bit s, input bit e, input logic [53:0] p,
                        input bit g, input string tag);
        bit was_act;
        @(negedge clk);
        cfg_new_data = s; cfg_tp_enable = e; cfg_tp_data = p; slot_grant = g;
        #1;
        check(tag, "slot_req", 54'(slot_req), 54'(m_act));
        if (m_act) begin
            check(tag, "tp_chars", 54'(tp_chars), 54'(m_cells[m_rd][47:0]));
            check(tag, "tp_kflags", 54'(tp_kflags), 54'(m_cells[m_rd][53:48]));
        end
        @(posedge clk);
        if (s && !m_sq) begin
            m_cells[m_wr] = p;
            m_wr = (m_wr + 1) % 8;
        end
        m_sq = s;
        was_act = m_act;
        if (was_act && g) begin
            if (m_rd == 7 && !e) m_act = 0;
            m_rd = (m_rd + 1) % 8;
        end else if (!was_act && e) begin
            m_act = 1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [53:0] keep;
        void'($urandom(32'h1A2B));
        for (int i = 0; i < 8; i++) m_cells[i] = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1 check("R1", "slot_req in reset", 54'(slot_req), 54'(0));
        @(negedge clk) rst = 1'b0;
        step(0, 0, '0, 0, "R1");
        step(0, 0, '0, 1, "R9");
        // R7 start, R1 zero cells, R6 stop only after cell 7
        step(0, 1, '0, 0, "R7");
        for (int i = 0; i < 3; i++) step(0, 1, '0, 1, "R1");
        for (int i = 0; i < 5; i++) step(0, 0, '0, 1, "R6");
        step(0, 0, '0, 1, "R6");
        step(0, 0, '0, 1, "R9");

        // R3: load a known entry, then seven more with the strobe held high
        step(1, 0, KNOWN, 0, "R3");
        step(0, 0, KNOWN, 0, "R3");
        for (int i = 0; i < 7; i++) begin
            keep = rnd_entry();
            step(1, 0, keep, 0, "R3");
            step(1, 0, rnd_entry(), 0, "R3");
            step(0, 0, rnd_entry(), 0, "R10");
        end
        step(0, 0, rnd_entry(), 0, "R10");

        // R2: per-character layout of cell 0
        step(0, 1, '0, 0, "R7");
        @(negedge clk);
        #1;
        for (int i = 0; i < 6; i++) begin
            checks++;
            if (tp_chars[8*i +: 8] !== KNOWN[8*i +: 8] || tp_kflags[i] !== KNOWN[48+i]) begin
                errors++;
                $display("FAIL R2 char %0d: actual %h/%b expected %h/%b", i,
                         tp_chars[8*i +: 8], tp_kflags[i], KNOWN[8*i +: 8], KNOWN[48+i]);
            end
        end

        // R4/R5: sparse grants over two rounds; R6: disable in mid-round
        for (int i = 0; i < 16; i++) begin
            step(0, 1, '0, 0, "R4");
            step(0, 1, '0, 1, "R5");
        end
        step(0, 1, '0, 1, "R5");
        step(0, 1, '0, 1, "R5");
        while (m_act) step(0, 0, '0, $urandom_range(0, 1), "R6");
        step(0, 0, '0, 1, "R9");

        // R3: ninth write wraps back to cell 0
        step(1, 0, rnd_entry(), 0, "R3");
        step(0, 0, '0, 0, "R3");

        // R8: write and granted read to the same cell in one cycle
        step(0, 1, '0, 0, "R8");
        while (m_rd != m_wr) step(0, 1, '0, 1, "R8");
        step(1, 1, rnd_entry(), 1, "R8");
        for (int i = 0; i < 9; i++) step(0, 1, '0, 1, "R8");
        while (m_act) step(0, 0, '0, 1, "R6");

        // Random mix
        for (int i = 0; i < 4000; i++)
            step($urandom_range(0, 3) == 0, $urandom_range(0, 9) != 0,
                 rnd_entry(), $urandom_range(0, 2) != 0, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule